// File: doc/BRIEF.md
# Device Control and Status Register File

This block is the byte-wide register file between a host bus and a parallel device port. The host selects one of eight byte registers with three address bits, which sit at bit positions 6:4 of the host byte address, so each register occupies its own 16-byte slot. Through these registers the host sets the transfer mode and the latched function controls, and writes and reads a 16-bit data latch as two bytes. Writes to the command slot fire single-cycle command strobes. Reads of that same slot return the flags and status byte.

The block catches the device attention signal through a synchronizer and keeps a sticky attention flag. It also keeps a sticky end-of-range flag, driven by the range logic next door. It raises an interrupt request when either flag is set and its mask bit allows it. A master-clear strobe resets the working registers and flags. The mode register is reset only by the bus reset. The handshake sequencing and the range counter live outside this block. Their three byte slots read as zero here.

Top module: `devif_regs`

## Requirements
- R1: While `rst_n` is low, every register, every flag, `pulse_o`, `irq_o` and `host_rdata` are zero.
- R2: The register is selected by `host_addr` (address bits 6:4). Code 0 is mode, 1 is functions, 2 is command/flags, 3 is the data high byte and 4 is the data low byte. A write to codes 0, 1, 3 or 4 is visible on the matching output after the write edge, and reads back unchanged at the same code.
- R3: A write to code 2 makes `pulse_o` equal to the written byte for exactly the one cycle after the write edge. In every other cycle `pulse_o` is zero. Bit 7 clears end-of-range, bit 6 clears attention, bit 5 terminates the handshake, bit 4 is master clear, bit 3 sends init, bit 2 sends the power-fail function pulse, bit 1 forces a cycle and bit 0 is go.
- R4: A read of code 2 returns the flags byte and never the byte last written there.
- R5: The attention flag (flags bit 6) sets one cycle after the synchronized attention level rises. It stays set until a command write with bit 6 or bit 4 set. Flags bit 5 shows the synchronized attention level, which lags `dev_attn` by two clock edges.
- R6: The end-of-range flag (flags bit 7) sets after any edge at which `eor_in` is high. It stays set until a command write with bit 7 or bit 4 set.
- R7: When a set condition and a clearing command write fall on the same edge, the flag ends up set.
- R8: Master clear (command bit 4) zeroes the functions register, the data latch and both flags at the write edge. The mode register changes only on a write to code 0 or on `rst_n`.
- R9: The function outputs map to bits of the functions register. Bit 0 drives `dir_in_o` (1 means input), bits 3:1 drive `fcn_o`, bit 4 drives `ctl_en_o` and bit 5 drives `range_dis_o`.
- R10: `irq_o` = (end-of-range flag AND functions bit 7) OR (attention flag AND functions bit 6).
- R11: `host_rdata` loads the selected byte at an edge where `host_rd` is high, and holds its value otherwise. Codes 5, 6 and 7 read as zero.
- R12: Flags bits 4:0 show `hs_mcerr` in bit 4, `dev_status[2:0]` in bits 3:1, and `hs_ready` in bit 0, as sampled at the read edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low bus reset |
| host_addr | input | 3 | Register select, byte address bits 6:4 |
| host_wdata | input | 8 | Host write data |
| host_wr | input | 1 | Write strobe |
| host_rd | input | 1 | Read strobe |
| host_rdata | output | 8 | Registered read data |
| dev_attn | input | 1 | Asynchronous attention level from the device |
| dev_status | input | 3 | Device status lines A, B, C |
| hs_ready | input | 1 | Ready state from the handshake logic |
| hs_mcerr | input | 1 | Multicycle error from the handshake logic |
| eor_in | input | 1 | End-of-range condition from the range counter |
| mode_o | output | 8 | Mode register contents |
| fcn_o | output | 3 | Function lines to the device |
| dir_in_o | output | 1 | Transfer direction, 1 = input |
| ctl_en_o | output | 1 | Control array enable |
| range_dis_o | output | 1 | Range counter disable |
| data_o | output | 16 | Data latch |
| pulse_o | output | 8 | Single-cycle command strobes |
| irq_o | output | 1 | Interrupt request |

## Verification
The critical overlap is a flag being set and cleared on the same edge. This happens when the synchronized attention rise or a high `eor_in` meets a command write that clears that flag. The bench times `dev_attn` so that its rise reaches the edge detector on exactly the edge that samples the reset-attention write. It also holds `eor_in` high during a reset-end-of-range write. In both cases it then reads the flags byte and expects the flag to be set. The long random phase lets master clear, flag sets and register writes collide freely. Each cycle it compares every output against a cycle-level model built from the requirements.

// File: rtl/devif_regs_pkg.sv
package devif_regs_pkg;

  // Register select codes (host address bits 6:4)
  typedef enum logic [2:0] {
    SEL_MODE  = 3'd0,
    SEL_FUNC  = 3'd1,
    SEL_CMD   = 3'd2,
    SEL_DHI   = 3'd3,
    SEL_DLO   = 3'd4,
    SEL_RHI   = 3'd5,
    SEL_RMID  = 3'd6,
    SEL_RLO   = 3'd7
  } reg_sel_e;

  // Command strobe bit positions
  localparam int CB_CLR_EOR  = 7;
  localparam int CB_CLR_ATTN = 6;
  localparam int CB_TERM     = 5;
  localparam int CB_MCLR     = 4;
  localparam int CB_INIT     = 3;
  localparam int CB_PWRFAIL  = 2;
  localparam int CB_CYCLE    = 1;
  localparam int CB_GO       = 0;

  // Functions register bit positions
  localparam int FB_EOR_MASK  = 7;
  localparam int FB_ATTN_MASK = 6;
  localparam int FB_RANGE_DIS = 5;
  localparam int FB_CTL_EN    = 4;
  localparam int FB_FCN_LSB   = 1;
  localparam int FB_FCN_W     = 3;
  localparam int FB_DIR_IN    = 0;

endpackage

// File: rtl/devif_sticky_flag.sv
module devif_sticky_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  logic flag_d;
  logic flag_q;

  // set takes priority over clear
  always_comb begin
    flag_d = set_i | (flag_q & ~clr_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= flag_d;
  end

  assign flag_o = flag_q;
endmodule

// File: rtl/devif_attn_capture.sv
module devif_attn_capture #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic attn_async,
  input  logic clr_i,
  output logic attn_live,
  output logic attn_flag
);
  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] sync_d;
  logic [MSB:0] sync_q;
  logic         prev_q;
  logic         rise;

  generate
    if (SYNC_STAGES > 1) begin : g_chain
      always_comb sync_d = {sync_q[MSB-1:0], attn_async};
    end else begin : g_single
      always_comb sync_d = attn_async;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
      prev_q <= 1'b0;
    end else begin
      sync_q <= sync_d;
      prev_q <= sync_q[MSB];
    end
  end

  assign rise      = sync_q[MSB] & ~prev_q;
  assign attn_live = sync_q[MSB];

  devif_sticky_flag i_flag (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (rise),
    .clr_i  (clr_i),
    .flag_o (attn_flag)
  );
endmodule

// File: rtl/devif_cmd_pulse.sv
module devif_cmd_pulse #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] pulse_o
);
  logic [DW-1:0] pulse_d;
  logic [DW-1:0] pulse_q;

  always_comb begin
    pulse_d = load_i ? wdata_i : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pulse_q <= '0;
    else        pulse_q <= pulse_d;
  end

  assign pulse_o = pulse_q;
endmodule

// File: rtl/devif_ctl_regs.sv
module devif_ctl_regs #(
  parameter int DW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr_mode_i,
  input  logic            wr_func_i,
  input  logic            wr_dhi_i,
  input  logic            wr_dlo_i,
  input  logic            mclr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   mode_o,
  output logic [DW-1:0]   func_o,
  output logic [2*DW-1:0] data_o
);
  logic [DW-1:0]   mode_d, mode_q;
  logic [DW-1:0]   func_d, func_q;
  logic [2*DW-1:0] data_d, data_q;
  logic            mode_en, func_en, data_en;

  always_comb begin
    mode_en = wr_mode_i;
    mode_d  = wdata_i;

    func_en = wr_func_i | mclr_i;
    func_d  = mclr_i ? '0 : wdata_i;

    data_en = wr_dhi_i | wr_dlo_i | mclr_i;
    data_d  = data_q;
    if (mclr_i) begin
      data_d = '0;
    end else begin
      if (wr_dhi_i) data_d[2*DW-1:DW] = wdata_i;
      if (wr_dlo_i) data_d[DW-1:0]    = wdata_i;
    end
  end

  // mode only responds to bus reset, never to master clear
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mode_q <= '0;
    else if (mode_en) mode_q <= mode_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       func_q <= '0;
    else if (func_en) func_q <= func_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       data_q <= '0;
    else if (data_en) data_q <= data_d;
  end

  assign mode_o = mode_q;
  assign func_o = func_q;
  assign data_o = data_q;
endmodule

// File: rtl/devif_regs.sv
module devif_regs
  import devif_regs_pkg::*;
#(
  parameter int DW          = 8,
  parameter int SEL_LSB     = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [SEL_LSB+2:SEL_LSB] host_addr,
  input  logic [DW-1:0]        host_wdata,
  input  logic                 host_wr,
  input  logic                 host_rd,
  output logic [DW-1:0]        host_rdata,
  input  logic                 dev_attn,
  input  logic [2:0]           dev_status,
  input  logic                 hs_ready,
  input  logic                 hs_mcerr,
  input  logic                 eor_in,
  output logic [DW-1:0]        mode_o,
  output logic [FB_FCN_W-1:0]  fcn_o,
  output logic                 dir_in_o,
  output logic                 ctl_en_o,
  output logic                 range_dis_o,
  output logic [2*DW-1:0]      data_o,
  output logic [DW-1:0]        pulse_o,
  output logic                 irq_o
);
  reg_sel_e      sel;
  logic          wr_cmd, mclr, clr_attn, clr_eor;
  logic          attn_live_w, attn_flag_w, eor_flag_w;
  logic [DW-1:0] func_w;
  logic [DW-1:0] flags_w;
  logic [DW-1:0] rd_mux;
  logic [DW-1:0] rdata_q;

  assign sel      = reg_sel_e'(host_addr);
  assign wr_cmd   = host_wr && (sel == SEL_CMD);
  assign mclr     = wr_cmd & host_wdata[CB_MCLR];
  assign clr_attn = wr_cmd & (host_wdata[CB_CLR_ATTN] | host_wdata[CB_MCLR]);
  assign clr_eor  = wr_cmd & (host_wdata[CB_CLR_EOR]  | host_wdata[CB_MCLR]);

  devif_ctl_regs #(.DW(DW)) i_ctl (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_mode_i (host_wr && (sel == SEL_MODE)),
    .wr_func_i (host_wr && (sel == SEL_FUNC)),
    .wr_dhi_i  (host_wr && (sel == SEL_DHI)),
    .wr_dlo_i  (host_wr && (sel == SEL_DLO)),
    .mclr_i    (mclr),
    .wdata_i   (host_wdata),
    .mode_o    (mode_o),
    .func_o    (func_w),
    .data_o    (data_o)
  );

  devif_cmd_pulse #(.DW(DW)) i_cmd (
    .clk     (clk),
    .rst_n   (rst_n),
    .load_i  (wr_cmd),
    .wdata_i (host_wdata),
    .pulse_o (pulse_o)
  );

  devif_attn_capture #(.SYNC_STAGES(SYNC_STAGES)) i_attn (
    .clk        (clk),
    .rst_n      (rst_n),
    .attn_async (dev_attn),
    .clr_i      (clr_attn),
    .attn_live  (attn_live_w),
    .attn_flag  (attn_flag_w)
  );

  devif_sticky_flag i_eor (
    .clk    (clk),
    .rst_n  (rst_n),
    .set_i  (eor_in),
    .clr_i  (clr_eor),
    .flag_o (eor_flag_w)
  );

  assign fcn_o       = func_w[FB_FCN_LSB +: FB_FCN_W];
  assign dir_in_o    = func_w[FB_DIR_IN];
  assign ctl_en_o    = func_w[FB_CTL_EN];
  assign range_dis_o = func_w[FB_RANGE_DIS];

  assign irq_o = (eor_flag_w & func_w[FB_EOR_MASK]) |
                 (attn_flag_w & func_w[FB_ATTN_MASK]);

  always_comb begin
    flags_w = {eor_flag_w, attn_flag_w, attn_live_w, hs_mcerr, dev_status, hs_ready};
    case (sel)
      SEL_MODE: rd_mux = mode_o;
      SEL_FUNC: rd_mux = func_w;
      SEL_CMD:  rd_mux = flags_w;
      SEL_DHI:  rd_mux = data_o[2*DW-1:DW];
      SEL_DLO:  rd_mux = data_o[DW-1:0];
      default:  rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (host_rd) rdata_q <= rd_mux;
  end

  assign host_rdata = rdata_q;
endmodule

// File: rtl/devif_regs_chk.sv
module devif_regs_chk #(
  parameter int DW      = 8,
  parameter int SEL_LSB = 4
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic [SEL_LSB+2:SEL_LSB] host_addr,
  input logic [DW-1:0]            host_wdata,
  input logic                     host_wr,
  input logic                     eor_in,
  input logic [DW-1:0]            mode_o,
  input logic [2:0]               fcn_o,
  input logic                     dir_in_o,
  input logic                     ctl_en_o,
  input logic                     range_dis_o,
  input logic [2*DW-1:0]          data_o,
  input logic [DW-1:0]            pulse_o,
  input logic                     irq_o,
  input logic                     attn_flag,
  input logic                     eor_flag,
  input logic [DW-1:0]            func_q
);
  logic cmd_wr;
  assign cmd_wr = host_wr && (host_addr == 3'd2);

  assert_pulse_value_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_wr |=> (pulse_o == $past(host_wdata)));

  assert_pulse_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_wr |=> (pulse_o == '0));

  assert_mode_kept_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(host_wr && host_addr == 3'd0) |=> $stable(mode_o));

  assert_mclr_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && host_wdata[4]) |=>
      (fcn_o == '0 && !dir_in_o && !ctl_en_o && !range_dis_o && data_o == '0));

  assert_attn_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (attn_flag && !(cmd_wr && (host_wdata[6] || host_wdata[4]))) |=> attn_flag);

  assert_eor_set_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
    eor_in |=> eor_flag);

  assert_irq_source_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ((eor_flag && func_q[7]) || (attn_flag && func_q[6])));
endmodule

bind devif_regs devif_regs_chk #(.DW(DW), .SEL_LSB(SEL_LSB)) i_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .host_addr   (host_addr),
  .host_wdata  (host_wdata),
  .host_wr     (host_wr),
  .eor_in      (eor_in),
  .mode_o      (mode_o),
  .fcn_o       (fcn_o),
  .dir_in_o    (dir_in_o),
  .ctl_en_o    (ctl_en_o),
  .range_dis_o (range_dis_o),
  .data_o      (data_o),
  .pulse_o     (pulse_o),
  .irq_o       (irq_o),
  .attn_flag   (attn_flag_w),
  .eor_flag    (eor_flag_w),
  .func_q      (func_w)
);

// File: tb/test_devif_regs.sv
`timescale 1ns/1ps
module test_devif_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [6:4]  host_addr = '0;
  logic [7:0]  host_wdata = '0;
  logic        host_wr = 1'b0;
  logic        host_rd = 1'b0;
  logic [7:0]  host_rdata;
  logic        dev_attn = 1'b0;
  logic [2:0]  dev_status = '0;
  logic        hs_ready = 1'b0;
  logic        hs_mcerr = 1'b0;
  logic        eor_in = 1'b0;
  logic [7:0]  mode_o;
  logic [2:0]  fcn_o;
  logic        dir_in_o, ctl_en_o, range_dis_o;
  logic [15:0] data_o;
  logic [7:0]  pulse_o;
  logic        irq_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;
  bit model_on = 0;

  always #2 clk = ~clk;

  devif_regs i_devif_regs (
    .clk(clk), .rst_n(rst_n), .host_addr(host_addr), .host_wdata(host_wdata),
    .host_wr(host_wr), .host_rd(host_rd), .host_rdata(host_rdata),
    .dev_attn(dev_attn), .dev_status(dev_status), .hs_ready(hs_ready),
    .hs_mcerr(hs_mcerr), .eor_in(eor_in), .mode_o(mode_o), .fcn_o(fcn_o),
    .dir_in_o(dir_in_o), .ctl_en_o(ctl_en_o), .range_dis_o(range_dis_o),
    .data_o(data_o), .pulse_o(pulse_o), .irq_o(irq_o)
  );

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", tag, what, act, exp, $time);
    end
  endtask

  // ---------------- cycle model built from the requirements ----------------
  logic       m_s1, m_s2, m_prev, m_attn, m_eor;
  logic [7:0] m_mode, m_func, m_pulse, m_rdata;
  logic [15:0] m_data;

  function automatic logic [7:0] exp_flags();
    return {m_eor, m_attn, m_s2, hs_mcerr, dev_status, hs_ready};
  endfunction

  function automatic logic [7:0] exp_read(logic [2:0] s);
    case (s)
      3'd0: return m_mode;
      3'd1: return m_func;
      3'd2: return exp_flags();
      3'd3: return m_data[15:8];
      3'd4: return m_data[7:0];
      default: return 8'h00;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_s1 <= 0; m_s2 <= 0; m_prev <= 0; m_attn <= 0; m_eor <= 0;
      m_mode <= 0; m_func <= 0; m_pulse <= 0; m_rdata <= 0; m_data <= 0;
    end else begin
      logic wc, mc;
      wc = host_wr && host_addr == 3'd2;
      mc = wc && host_wdata[4];
      m_s1   <= dev_attn;
      m_s2   <= m_s1;
      m_prev <= m_s2;
      m_attn <= (m_s2 & ~m_prev) | (m_attn & ~(wc & (host_wdata[6] | host_wdata[4])));
      m_eor  <= eor_in | (m_eor & ~(wc & (host_wdata[7] | host_wdata[4])));
      m_pulse <= wc ? host_wdata : 8'h00;
      if (host_wr && host_addr == 3'd0) m_mode <= host_wdata;
      if (mc) m_func <= 0;
      else if (host_wr && host_addr == 3'd1) m_func <= host_wdata;
      if (mc) m_data <= 0;
      else if (host_wr && host_addr == 3'd3) m_data[15:8] <= host_wdata;
      else if (host_wr && host_addr == 3'd4) m_data[7:0] <= host_wdata;
      if (host_rd) m_rdata <= exp_read(host_addr);
    end
  end

  always @(negedge clk) begin
    if (model_on && rst_n) begin
      chk("R3", pulse_o, m_pulse, "pulse_o");
      chk("R10", irq_o, (m_eor & m_func[7]) | (m_attn & m_func[6]), "irq_o");
      chk("R8", mode_o, m_mode, "mode_o");
      chk("R9", {range_dis_o, ctl_en_o, fcn_o, dir_in_o}, {m_func[5:4], m_func[3:1], m_func[0]}, "function outputs");
      chk("R2", data_o, m_data, "data_o");
      chk("R11", host_rdata, m_rdata, "host_rdata");
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic do_wr(logic [2:0] s, logic [7:0] d);
    @(negedge clk);
    host_addr = s; host_wdata = d; host_wr = 1;
    @(negedge clk);
    host_wr = 0;
  endtask

  task automatic do_rd(logic [2:0] s, output logic [7:0] v);
    @(negedge clk);
    host_addr = s; host_rd = 1;
    @(negedge clk);
    host_rd = 0;
    v = host_rdata;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int seed;
    seed = 32'h5eed;
    void'($urandom(seed));

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1", {mode_o, pulse_o, data_o, fcn_o, dir_in_o, ctl_en_o, range_dis_o, irq_o, host_rdata}, '0, "reset outputs");
    rst_n = 1;
    model_on = 1;

    // R2: mode and data registers
    do_wr(3'd0, 8'hA5);
    do_rd(3'd0, v); chk("R2", v, 8'hA5, "mode readback");
    do_wr(3'd3, 8'h3C); do_wr(3'd4, 8'hC3);
    chk("R2", data_o, 16'h3CC3, "data latch");

    // R3/R4: command strobes, flags readback
    @(negedge clk); host_addr = 3'd2; host_wdata = 8'h2F; host_wr = 1;
    @(negedge clk); host_wr = 0;
    chk("R3", pulse_o, 8'h2F, "strobe cycle");
    @(negedge clk); chk("R3", pulse_o, 8'h00, "strobe gone");
    do_rd(3'd2, v); chk("R4", v, 8'h00, "cmd slot reads flags");

    // R12: status passthrough
    dev_status = 3'b101; hs_ready = 1; hs_mcerr = 1;
    do_rd(3'd2, v); chk("R12", v[4:0], 5'b1_101_1, "status bits");
    dev_status = 0; hs_ready = 0; hs_mcerr = 0;

    // R5: attention capture and clear
    dev_attn = 1; repeat (4) @(negedge clk);
    do_rd(3'd2, v); chk("R5", v[6:5], 2'b11, "attention set and live");
    dev_attn = 0; repeat (4) @(negedge clk);
    do_rd(3'd2, v); chk("R5", v[6:5], 2'b10, "attention sticky");
    do_wr(3'd2, 8'h40);
    do_rd(3'd2, v); chk("R5", v[6], 1'b0, "attention cleared");

    // R6: end-of-range
    @(negedge clk); eor_in = 1; @(negedge clk); eor_in = 0;
    do_rd(3'd2, v); chk("R6", v[7], 1'b1, "eor set");
    do_wr(3'd2, 8'h80);
    do_rd(3'd2, v); chk("R6", v[7], 1'b0, "eor cleared");

    // R7: attention rise collides with reset-attention write
    dev_attn = 1;
    @(negedge clk); @(negedge clk);
    host_addr = 3'd2; host_wdata = 8'h40; host_wr = 1;
    @(negedge clk); host_wr = 0;
    do_rd(3'd2, v); chk("R7", v[6], 1'b1, "attention set wins");
    dev_attn = 0;
    // R7: eor held high during reset-eor write
    @(negedge clk); eor_in = 1; host_addr = 3'd2; host_wdata = 8'h80; host_wr = 1;
    @(negedge clk); host_wr = 0; eor_in = 0;
    do_rd(3'd2, v); chk("R7", v[7], 1'b1, "eor set wins");

    // R10: interrupt masking
    do_wr(3'd1, 8'h40);
    chk("R10", irq_o, 1'b1, "attention irq enabled");
    do_wr(3'd1, 8'h00);
    chk("R10", irq_o, 1'b0, "irq masked");
    do_wr(3'd1, 8'h80);
    chk("R10", irq_o, 1'b1, "eor irq enabled");

    // R9: function mapping
    do_wr(3'd1, 8'h3B);
    chk("R9", {range_dis_o, ctl_en_o, fcn_o, dir_in_o}, 6'b1_1_101_1, "function fields");

    // R8: master clear keeps mode
    do_wr(3'd2, 8'h10);
    chk("R8", mode_o, 8'hA5, "mode kept on master clear");
    chk("R8", {fcn_o, dir_in_o, ctl_en_o, range_dis_o, data_o}, '0, "cleared registers");
    do_rd(3'd2, v); chk("R8", v[7:6], 2'b00, "flags cleared");

    // R11: range slots read zero, rdata holds
    do_rd(3'd6, v); chk("R11", v, 8'h00, "range slot");
    do_rd(3'd0, v);
    repeat (3) @(negedge clk);
    chk("R11", host_rdata, 8'hA5, "rdata held");

    // random phase
    for (int i = 0; i < 4000; i++) begin
      @(negedge clk);
      host_addr  = 3'($urandom_range(0, 7));
      host_wdata = 8'($urandom);
      host_wr    = ($urandom_range(0, 2) == 0);
      host_rd    = ($urandom_range(0, 1) == 0);
      if ($urandom_range(0, 15) == 0) dev_attn = ~dev_attn;
      eor_in     = ($urandom_range(0, 19) == 0);
      if ($urandom_range(0, 7) == 0) begin
        dev_status = 3'($urandom); hs_ready = 1'($urandom); hs_mcerr = 1'($urandom);
      end
    end
    @(negedge clk); host_wr = 0; host_rd = 0;
    @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule